// File: doc/BRIEF.md
# Backplane Bus Grant Arbiter

This block is the grant logic of a backplane where several card slots share one request line toward a host processor. Any slot may raise its request. The block forwards the combined request to the host. When the host answers with an acknowledge, the block picks one card to receive it. The same structure serves a bus-mastership request/acknowledge pair and an interrupt-acknowledge chain.

A build-time parameter chooses one of two arbitration styles:

- **Serial.** The acknowledge enters slot 0 and ripples from cell to cell. A cell that is not requesting passes the acknowledge on. A requesting cell blocks it. The ripple is modelled as one slot per clock.
- **Parallel.** A priority encoder picks the requesting slot with the lowest index. Its index drives a decoder that is enabled by the acknowledge.

In both styles the block holds a wait request toward the host while the grant is still settling. The requests are captured when the acknowledge rises, so a grant cannot be taken away until the acknowledge drops.

Top module: `bus_grant_arbiter`

## Requirements
- R1: `host_req` equals the OR of all bits of `slot_req` from the previous clock edge, in both styles.
- R2: Serial style: in the first cycle after the rising edge of `host_ack`, `grant_in` is 1 for slot 0 only. Any slot with `grant_in` high that did not request at that edge drives its `grant_out` high. A slot that did request keeps its `grant_out` low.
- R3: Serial style: the acknowledge moves one slot per clock. `grant_in[i+1]` rises one cycle after `grant_out[i]`. While `host_ack` stays high, a `grant_in` bit never falls.
- R4: The lowest-index slot that requested at the rising edge of `host_ack` wins. No requesting slot with a higher index ever sees `grant_in` high.
- R5: Serial style: `host_wait` is high for w+1 cycles after `host_ack` rises, where w is the index of the winning slot. With no requester it is high for N_SLOTS cycles.
- R6: Requests that change while `host_ack` is high alter no grant, even if a higher-priority slot starts requesting.
- R7: Parallel style: one cycle after the rising edge of `host_ack`, `grant_in` is the one-hot code of the winning slot (bit i means slot i). `grant_out` stays all zero.
- R8: Parallel style: `host_wait` is high for WAIT_CYCLES cycles after `host_ack` rises.
- R9: An acknowledge with no active request grants no requester. Parallel style: `grant_in` stays zero. Serial style: the acknowledge runs through the whole chain, and every bit of `grant_out` ends high.
- R10: `host_wait` is low whenever `host_ack` is low. One clock edge after `host_ack` falls, `grant_in` and `grant_out` are all zero.
- R11: While `rst` is high, `host_req`, `grant_in` and `grant_out` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_req | input | N_SLOTS | Request line of each slot, active high |
| host_ack | input | 1 | Acknowledge from the host |
| host_req | output | 1 | Combined request to the host, registered |
| grant_in | output | N_SLOTS | Grant arriving at each slot |
| grant_out | output | N_SLOTS | Grant passed on by each slot (serial style only) |
| host_wait | output | 1 | Asks the host to stretch its acknowledge cycle |

## Verification
The checker tests the following on every cycle:

- the one-cycle relation between the requests and `host_req`;
- the rule that `host_wait` is low whenever `host_ack` is low;
- the clearing of grants after the acknowledge falls;
- the rule that serial grants only accumulate and never pass a requesting slot;
- the one-hot, stable parallel grant and its silent `grant_out`.

Only the bench scenarios can show the rest:

- which slot wins for a given request pattern;
- the exact number of wait cycles;
- the behaviour of a request that arrives in the middle of a grant.

// File: rtl/bga_pkg.sv
package bga_pkg;
  typedef enum logic {ARB_SERIAL = 1'b0, ARB_PARALLEL = 1'b1} arb_style_e;
endpackage

// File: rtl/bga_serial_chain.sv
module bga_serial_chain #(
  parameter int N_SLOTS = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ack,
  input  logic               ack_rise,
  input  logic [N_SLOTS-1:0] slot_req,
  output logic               any_req,
  output logic [N_SLOTS-1:0] grant_in,
  output logic [N_SLOTS-1:0] grant_out,
  output logic               settled
);
  logic [N_SLOTS-1:0] reach_q;
  logic [N_SLOTS-1:0] snap_q;
  logic [N_SLOTS-1:0] reach_nx;

  assign any_req = |slot_req;

  // One pass-through cell per slot: each cell forwards the token unless its slot requested.
  for (genvar i = 0; i < N_SLOTS; i++) begin : g_cell
    assign grant_out[i] = reach_q[i] & ~snap_q[i];
    if (i == 0) begin : g_head
      assign reach_nx[i] = reach_q[i];
    end else begin : g_link
      assign reach_nx[i] = reach_q[i] | grant_out[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !ack) begin
      reach_q <= '0;
      snap_q  <= '0;
    end else if (ack_rise) begin
      reach_q <= N_SLOTS'(1);
      snap_q  <= slot_req;
    end else begin
      reach_q <= reach_nx;
    end
  end

  assign grant_in = reach_q;
  assign settled  = (|(reach_q & snap_q)) | grant_out[N_SLOTS-1];
endmodule

// File: rtl/bga_parallel_sel.sv
module bga_parallel_sel #(
  parameter int N_SLOTS     = 4,
  parameter int WAIT_CYCLES = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ack,
  input  logic               ack_rise,
  input  logic [N_SLOTS-1:0] slot_req,
  output logic               any_req,
  output logic [N_SLOTS-1:0] grant_in,
  output logic [N_SLOTS-1:0] grant_out,
  output logic               settled
);
  localparam int IDX_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1;
  localparam int CNT_W = $clog2(WAIT_CYCLES + 1) + 1;

  logic [IDX_W-1:0]   win_idx;
  logic [N_SLOTS-1:0] decoded;
  logic [N_SLOTS-1:0] sel_q;
  logic [CNT_W-1:0]   cnt_q;

  // Priority encoder: the lowest index wins.
  always_comb begin
    win_idx = '0;
    for (int i = N_SLOTS - 1; i >= 0; i--) begin
      if (slot_req[i]) win_idx = IDX_W'(i);
    end
  end
  assign any_req = |slot_req;

  // Decoder, enabled only when the encoder reports a request.
  for (genvar i = 0; i < N_SLOTS; i++) begin : g_dec
    assign decoded[i] = any_req && (win_idx == IDX_W'(i));
  end

  always_ff @(posedge clk) begin
    if (rst || !ack) begin
      sel_q <= '0;
      cnt_q <= '0;
    end else begin
      if (ack_rise) sel_q <= decoded;
      if (cnt_q < CNT_W'(WAIT_CYCLES)) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign grant_in  = sel_q;
  assign grant_out = '0;
  assign settled   = (cnt_q >= CNT_W'(WAIT_CYCLES));
endmodule

// File: rtl/bus_grant_arbiter.sv
module bus_grant_arbiter #(
  parameter int                  N_SLOTS     = 4,
  parameter bga_pkg::arb_style_e STYLE       = bga_pkg::ARB_SERIAL,
  parameter int                  WAIT_CYCLES = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_SLOTS-1:0] slot_req,
  input  logic               host_ack,
  output logic               host_req,
  output logic [N_SLOTS-1:0] grant_in,
  output logic [N_SLOTS-1:0] grant_out,
  output logic               host_wait
);
  logic ack_q;
  logic ack_rise;
  logic any_req;
  logic settled;

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q    <= 1'b0;
      host_req <= 1'b0;
    end else begin
      ack_q    <= host_ack;
      host_req <= any_req;
    end
  end
  assign ack_rise = host_ack & ~ack_q;

  if (STYLE == bga_pkg::ARB_SERIAL) begin : g_serial
    bga_serial_chain #(.N_SLOTS(N_SLOTS)) u_chain (
      .clk(clk), .rst(rst), .ack(host_ack), .ack_rise(ack_rise),
      .slot_req(slot_req), .any_req(any_req), .grant_in(grant_in),
      .grant_out(grant_out), .settled(settled)
    );
  end else begin : g_parallel
    bga_parallel_sel #(.N_SLOTS(N_SLOTS), .WAIT_CYCLES(WAIT_CYCLES)) u_sel (
      .clk(clk), .rst(rst), .ack(host_ack), .ack_rise(ack_rise),
      .slot_req(slot_req), .any_req(any_req), .grant_in(grant_in),
      .grant_out(grant_out), .settled(settled)
    );
  end

  assign host_wait = host_ack & ~settled;
endmodule

// File: rtl/bga_checker.sv
module bga_checker #(
  parameter int                  N_SLOTS = 4,
  parameter bga_pkg::arb_style_e STYLE   = bga_pkg::ARB_SERIAL
) (
  input logic               clk,
  input logic               rst,
  input logic [N_SLOTS-1:0] slot_req,
  input logic               host_ack,
  input logic               host_req,
  input logic [N_SLOTS-1:0] grant_in,
  input logic [N_SLOTS-1:0] grant_out,
  input logic               host_wait
);
  // R1
  req_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (host_req == $past(|slot_req)));

  // R10
  wait_needs_ack_chk: assert property (@(posedge clk) disable iff (rst)
    !host_ack |-> !host_wait);

  // R10
  grant_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(host_ack) |=> (grant_in == '0 && grant_out == '0));

  if (STYLE == bga_pkg::ARB_SERIAL) begin : g_ser_chk
    // R3
    grant_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      (host_ack && $past(host_ack) && !$past(rst))
        |-> ((grant_in & $past(grant_in)) == $past(grant_in)));

    // R2
    out_needs_in_chk: assert property (@(posedge clk) disable iff (rst)
      (grant_out & ~grant_in) == '0);
  end else begin : g_par_chk
    // R7
    onehot_grant_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(grant_in) && grant_out == '0);

    // R6
    grant_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (host_ack && $past(host_ack) && $past(host_ack, 2) && !$past(rst) && !$past(rst, 2))
        |-> $stable(grant_in));

    // R9
    idle_ack_chk: assert property (@(posedge clk) disable iff (rst)
      ($rose(host_ack) && slot_req == '0 && !$past(rst)) |=> (grant_in == '0));
  end
endmodule

bind bus_grant_arbiter bga_checker #(.N_SLOTS(N_SLOTS), .STYLE(STYLE)) u_bga_chk (
  .clk(clk), .rst(rst), .slot_req(slot_req), .host_ack(host_ack),
  .host_req(host_req), .grant_in(grant_in), .grant_out(grant_out),
  .host_wait(host_wait)
);

// File: tb/bus_grant_arbiter_test.sv
module bus_grant_arbiter_test;
  localparam int N     = 4;
  localparam int PWAIT = 2;
  localparam int NONE  = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] slot_req = '0;
  logic         host_ack = 1'b0;
  logic         s_req, p_req, s_wait, p_wait;
  logic [N-1:0] s_gi, s_go, p_gi, p_go;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  bus_grant_arbiter #(.N_SLOTS(N), .STYLE(bga_pkg::ARB_SERIAL)) uut (
    .clk(clk), .rst(rst), .slot_req(slot_req), .host_ack(host_ack),
    .host_req(s_req), .grant_in(s_gi), .grant_out(s_go), .host_wait(s_wait));

  bus_grant_arbiter #(.N_SLOTS(N), .STYLE(bga_pkg::ARB_PARALLEL), .WAIT_CYCLES(PWAIT)) uut_par (
    .clk(clk), .rst(rst), .slot_req(slot_req), .host_ack(host_ack),
    .host_req(p_req), .grant_in(p_gi), .grant_out(p_go), .host_wait(p_wait));

  // Each entry: request pattern [6:3], winning slot [2:0] (4 means no winner).
  localparam logic [6:0] VEC [6] = '{
    {4'b0000, 3'd4}, {4'b0001, 3'd0}, {4'b0110, 3'd1},
    {4'b1000, 3'd3}, {4'b1100, 3'd2}, {4'b1111, 3'd0}
  };

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic run_ack(output int ws, output int wp);
    ws = 0; wp = 0;
    @(negedge clk); host_ack = 1'b1; #1;
    for (int k = 0; k < 10; k++) begin
      ws += int'(s_wait); wp += int'(p_wait);
      @(negedge clk); #1;
    end
  endtask

  task automatic drop_ack();
    @(negedge clk); host_ack = 1'b0; #1;
    check(!s_wait && !p_wait, "R10 wait low", {s_wait, p_wait}, 0);
    @(negedge clk); #1;
    check(s_gi == 0 && s_go == 0 && p_gi == 0, "R10 grants cleared", {s_gi, s_go, p_gi}, 0);
  endtask

  initial begin
    int ws, wp;
    repeat (3) @(negedge clk);
    #1;
    check(!s_req && !p_req && s_gi == 0 && s_go == 0 && p_gi == 0 && p_go == 0,
          "R11 reset state", {s_req, p_req, s_gi, s_go, p_gi}, 0);
    @(negedge clk); rst = 1'b0;

    foreach (VEC[v]) begin
      logic [N-1:0] rq;
      int w;
      logic [N-1:0] e_sgi, e_sgo, e_pgi;
      int e_ws;
      rq = VEC[v][6:3];
      w  = int'(VEC[v][2:0]);
      e_sgi = (w == NONE) ? 4'b1111 : 4'((1 << (w + 1)) - 1);
      e_sgo = (w == NONE) ? 4'b1111 : 4'((1 << w) - 1);
      e_pgi = (w == NONE) ? 4'b0000 : 4'(1 << w);
      e_ws  = (w == NONE) ? N : w + 1;
      @(negedge clk); slot_req = rq;
      @(negedge clk); #1;
      check(s_req == (|rq) && p_req == (|rq), "R1 host_req", {s_req, p_req}, {2{|rq}});
      run_ack(ws, wp);
      check(ws == e_ws, "R5 serial wait count", ws, e_ws);
      check(wp == PWAIT, "R8 parallel wait count", wp, PWAIT);
      check(s_gi == e_sgi, "R4 serial grant_in", s_gi, e_sgi);
      check(s_go == e_sgo, "R2 serial grant_out", s_go, e_sgo);
      check(p_gi == e_pgi, "R7 parallel grant_in", p_gi, e_pgi);
      check(p_go == 0, "R7 parallel grant_out", p_go, 0);
      if (w == NONE) check(s_go[N-1] && p_gi == 0, "R9 idle ack", {s_go, p_gi}, 8'h80);
      drop_ack();
    end

    // R3: the token advances one slot per clock toward a requester in slot 3.
    @(negedge clk); slot_req = 4'b1000;
    @(negedge clk); host_ack = 1'b1;
    @(negedge clk); #1;
    check(s_gi == 4'b0001, "R2 slot0 first", s_gi, 1);
    @(negedge clk); #1;
    check(s_gi == 4'b0011, "R3 one hop", s_gi, 3);
    @(negedge clk); #1;
    check(s_gi == 4'b0111 && s_wait, "R3 two hops", {s_wait, s_gi}, 5'h17);
    drop_ack();

    // R6: a higher-priority request that arrives mid-grant does not take the grant.
    @(negedge clk); slot_req = 4'b0100;
    run_ack(ws, wp);
    @(negedge clk); slot_req = 4'b0101;
    repeat (4) @(negedge clk);
    #1;
    check(s_gi == 4'b0111 && s_go == 4'b0011, "R6 serial hold", {s_gi, s_go}, 8'h73);
    check(p_gi == 4'b0100, "R6 parallel hold", p_gi, 4);
    check(!s_wait && !p_wait, "R6 wait stays low", {s_wait, p_wait}, 0);
    drop_ack();

    // R11: reset in the middle of a grant.
    @(negedge clk); host_ack = 1'b1;
    repeat (3) @(negedge clk);
    host_ack = 1'b0; rst = 1'b1;
    @(negedge clk); #1;
    check(!s_req && !p_req && s_gi == 0 && p_gi == 0, "R11 mid reset", {s_req, p_req, s_gi, p_gi}, 0);
    rst = 1'b0;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule